// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

One pulse-width-modulation channel. A counter, 24 bits wide by default, advances on a tick. The tick is the counter clock divided by 1, 16, 256 or 2048. The count is compared against a programmable period and a programmable duty to form one output, and that output can be inverted. Three events raise interrupt requests: a rising edge of the output, a falling edge of the output, and the counter wrapping back to zero.

Settings are written from a bus clock that has no fixed relation to the counter clock; either clock may be the faster. A load strobe on the bus side captures a complete setting. A toggle request/acknowledge handshake carries that setting into the counter domain. The counter then adopts it only at the next wrap, so a running period is never cut short. Events return to the bus side as toggles, which are synchronized and edge-detected into sticky status bits. Each status bit has an enable bit, and the enabled status bits are merged into one interrupt line.

Top module: `pwm_timer_channel`

## Requirements
- R1: While reset is held and directly after it is released, `pwm_out` is 0, `stat` is 0 and `irq` is 0.
- R2: On each tick the count rises by one. When it equals the period value, the next tick returns it to 0 instead. One output cycle therefore lasts period+1 ticks. A duty d with 0 < d < period makes the output active (before inversion) for the d ticks with count < d.
- R3: A duty of 0 keeps the output inactive for the whole cycle. A duty of period or greater keeps it active for the whole cycle.
- R4: When `cfg_invert` is 1, the output is the complement of the non-inverted waveform.
- R5: `cfg_psel` selects the tick rate: 0 gives every counter clock, 1 gives every 16th, 2 gives every 256th, 3 gives every 2048th.
- R6: A loaded setting (period, duty, select, invert) takes effect only when the counter wraps to 0. The cycle in progress keeps the previous setting.
- R7: When `cfg_load` pulses again while an earlier setting is still crossing, the newest setting is the one that finally takes effect.
- R8: `stat` bit 0 records a rising edge of `pwm_out`, bit 1 a falling edge, and bit 2 a counter wrap. A set bit stays set until a 1 is written to the same bit of `stat_clr`. A new event in the same cycle as the clear wins.
- R9: `irq` is high exactly when some bit of `stat` is set and the `irq_en` bit at the same position is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-side clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| cfg_load | input | 1 | One-cycle strobe capturing the setting inputs |
| cfg_period | input | CNT_W | Final count value before wrap |
| cfg_duty | input | CNT_W | Active-phase length in ticks |
| cfg_psel | input | 2 | Tick rate select |
| cfg_invert | input | 1 | Output inversion |
| irq_en | input | 3 | Per-event interrupt enables |
| stat_clr | input | 3 | Write-one-to-clear strobes for `stat` |
| stat | output | 3 | Sticky event flags (rise, fall, wrap) |
| irq | output | 1 | Combined interrupt request |
| cnt_clk | input | 1 | Counter clock |
| cnt_rst_n | input | 1 | Active-low reset, counter domain |
| pwm_out | output | 1 | PWM output, counter domain |

## Verification
The bench sweeps duty across the whole range for a short period, including 0, the period value itself and one above it. A design that is off by one at either end would show a lost or spurious active tick per cycle, or fail to reach 0% or 100%. Every tick rate is measured over exact multiples of the output cycle, so a wrong divider ratio shows up as a wrong count of active samples. Two further probes load a new duty just after a wrap, and issue two loads one bus cycle apart. A design that applies a setting mid-cycle, or that drops the second load while the first is in flight, produces the wrong output level inside the window the bench watches.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
   typedef enum logic [1:0] {
      PSC_1    = 2'd0,
      PSC_16   = 2'd1,
      PSC_256  = 2'd2,
      PSC_2048 = 2'd3
   } psc_sel_e;

   localparam int EV_RISE = 0;
   localparam int EV_FALL = 1;
   localparam int EV_WRAP = 2;
   localparam int NUM_EV  = 3;
endpackage

// File: rtl/pwm_sync.sv
`timescale 1ns/1ps
module pwm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_cfg_xfer.sv
`timescale 1ns/1ps
module pwm_cfg_xfer #(
   parameter int CFG_W       = 51,
   parameter int SYNC_STAGES = 2
) (
   input  logic             bus_clk,
   input  logic             bus_rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] wr_cfg,
   input  logic             cnt_clk,
   input  logic             cnt_rst_n,
   input  logic             take,
   output logic [CFG_W-1:0] stg_cfg,
   output logic             stg_vld,
   output logic             busy,
   output logic [CFG_W-1:0] shadow
);
   // bus side
   logic             req_t, ack_s, pend;
   logic [CFG_W-1:0] next_cfg, shadow_q;
   // counter side
   logic             req_s, seen;

   assign busy   = (req_t != ack_s);
   assign shadow = shadow_q;

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         req_t    <= 1'b0;
         pend     <= 1'b0;
         next_cfg <= '0;
         shadow_q <= '0;
      end else if (!busy) begin
         if (load) begin
            shadow_q <= wr_cfg;
            req_t    <= ~req_t;
            pend     <= 1'b0;
         end else if (pend) begin
            shadow_q <= next_cfg;
            req_t    <= ~req_t;
            pend     <= 1'b0;
         end
      end else if (load) begin
         next_cfg <= wr_cfg;
         pend     <= 1'b1;
      end
   end

   pwm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk(cnt_clk), .rst_n(cnt_rst_n), .d(req_t), .q(req_s));

   pwm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(seen), .q(ack_s));

   always_ff @(posedge cnt_clk or negedge cnt_rst_n) begin
      if (!cnt_rst_n) begin
         seen    <= 1'b0;
         stg_cfg <= '0;
         stg_vld <= 1'b0;
      end else if (req_s != seen) begin
         // shadow_q is frozen while the request is outstanding
         stg_cfg <= shadow_q;
         stg_vld <= 1'b1;
         seen    <= req_s;
      end else if (take) begin
         stg_vld <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
   parameter int LOG_D1 = 4,
   parameter int LOG_D2 = 8,
   parameter int LOG_D3 = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] psel,
   output logic       tick
);
   import pwm_pkg::*;
   localparam int DW = LOG_D3;

   if (!(LOG_D1 > 0 && LOG_D1 < LOG_D2 && LOG_D2 < LOG_D3)) begin : g_bad_div
      $error("pwm_prescaler: divider exponents must rise strictly");
   end

   logic [DW-1:0] pdiv, limit;

   always_comb begin
      unique case (psc_sel_e'(psel))
         PSC_1:    limit = '0;
         PSC_16:   limit = DW'((1 << LOG_D1) - 1);
         PSC_256:  limit = DW'((1 << LOG_D2) - 1);
         default:  limit = DW'((1 << LOG_D3) - 1);
      endcase
   end

   assign tick = (pdiv == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pdiv <= '0;
      else if (tick) pdiv <= '0;
      else           pdiv <= pdiv + DW'(1);
   end
endmodule

// File: rtl/pwm_count_cmp.sv
`timescale 1ns/1ps
module pwm_count_cmp #(
   parameter int CNT_W = 24,
   localparam int CFG_W = 2*CNT_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CFG_W-1:0] stg_cfg,
   input  logic             stg_vld,
   output logic             take,
   output logic [1:0]       act_psel,
   output logic             pwm_out,
   output logic [2:0]       ev_tgl,
   output logic [CNT_W-1:0] cnt,
   output logic [CFG_W-1:0] act_cfg,
   output logic             wrap
);
   import pwm_pkg::*;

   logic [CNT_W-1:0] period, duty;
   logic             inv, at_end, lvl;

   assign period   = act_cfg[CNT_W-1:0];
   assign duty     = act_cfg[2*CNT_W-1:CNT_W];
   assign act_psel = act_cfg[2*CNT_W+1:2*CNT_W];
   assign inv      = act_cfg[2*CNT_W+2];

   assign at_end = (cnt == period);
   assign wrap   = tick && at_end;
   assign take   = wrap && stg_vld;
   assign lvl    = ((duty != '0) && ((cnt < duty) || (duty >= period))) ^ inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         act_cfg <= '0;
         pwm_out <= 1'b0;
         ev_tgl  <= '0;
      end else begin
         pwm_out <= lvl;
         if (lvl && !pwm_out) ev_tgl[EV_RISE] <= ~ev_tgl[EV_RISE];
         if (!lvl && pwm_out) ev_tgl[EV_FALL] <= ~ev_tgl[EV_FALL];
         if (wrap)            ev_tgl[EV_WRAP] <= ~ev_tgl[EV_WRAP];
         if (tick) begin
            if (at_end) begin
               cnt <= '0;
               if (stg_vld) act_cfg <= stg_cfg;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/pwm_evt_flags.sv
`timescale 1ns/1ps
module pwm_evt_flags #(
   parameter int NUM_EV      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] tgl_in,
   input  logic [NUM_EV-1:0] en,
   input  logic [NUM_EV-1:0] clr,
   output logic [NUM_EV-1:0] stat,
   output logic              irq
);
   logic [NUM_EV-1:0] tgl_s, tgl_d;

   pwm_sync #(.W(NUM_EV), .STAGES(SYNC_STAGES)) u_tgl_sync (
      .clk(clk), .rst_n(rst_n), .d(tgl_in), .q(tgl_s));

   for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tgl_d[g] <= 1'b0;
            stat[g]  <= 1'b0;
         end else begin
            tgl_d[g] <= tgl_s[g];
            if (tgl_s[g] != tgl_d[g]) stat[g] <= 1'b1;
            else if (clr[g])          stat[g] <= 1'b0;
         end
      end
   end

   assign irq = |(stat & en);
endmodule

// File: rtl/pwm_timer_channel.sv
`timescale 1ns/1ps
module pwm_timer_channel #(
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int LOG_D1      = 4,
   parameter int LOG_D2      = 8,
   parameter int LOG_D3      = 11
) (
   input  logic             bus_clk,
   input  logic             bus_rst_n,
   input  logic             cfg_load,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [CNT_W-1:0] cfg_duty,
   input  logic [1:0]       cfg_psel,
   input  logic             cfg_invert,
   input  logic [2:0]       irq_en,
   input  logic [2:0]       stat_clr,
   output logic [2:0]       stat,
   output logic             irq,
   input  logic             cnt_clk,
   input  logic             cnt_rst_n,
   output logic             pwm_out
);
   localparam int CFG_W = 2*CNT_W + 3;

   if (CNT_W < 2) begin : g_bad_width
      $error("pwm_timer_channel: CNT_W must be at least 2");
   end

   logic [CFG_W-1:0] wr_cfg, stg_cfg, xfer_cfg, act_cfg;
   logic             stg_vld, take, cfg_busy, tick, wrap;
   logic [1:0]       act_psel;
   logic [2:0]       ev_tgl;
   logic [CNT_W-1:0] cnt_val;

   assign wr_cfg = {cfg_invert, cfg_psel, cfg_duty, cfg_period};

   pwm_cfg_xfer #(.CFG_W(CFG_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .load(cfg_load), .wr_cfg(wr_cfg),
      .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n), .take(take),
      .stg_cfg(stg_cfg), .stg_vld(stg_vld), .busy(cfg_busy), .shadow(xfer_cfg));

   pwm_prescaler #(.LOG_D1(LOG_D1), .LOG_D2(LOG_D2), .LOG_D3(LOG_D3)) u_psc (
      .clk(cnt_clk), .rst_n(cnt_rst_n), .psel(act_psel), .tick(tick));

   pwm_count_cmp #(.CNT_W(CNT_W)) u_cnt (
      .clk(cnt_clk), .rst_n(cnt_rst_n), .tick(tick),
      .stg_cfg(stg_cfg), .stg_vld(stg_vld), .take(take), .act_psel(act_psel),
      .pwm_out(pwm_out), .ev_tgl(ev_tgl), .cnt(cnt_val), .act_cfg(act_cfg),
      .wrap(wrap));

   pwm_evt_flags #(.NUM_EV(3), .SYNC_STAGES(SYNC_STAGES)) u_flags (
      .clk(bus_clk), .rst_n(bus_rst_n), .tgl_in(ev_tgl), .en(irq_en),
      .clr(stat_clr), .stat(stat), .irq(irq));
endmodule

// File: rtl/pwm_timer_channel_chk.sv
`timescale 1ns/1ps
module pwm_timer_channel_chk #(
   parameter int CNT_W = 24,
   localparam int CFG_W = 2*CNT_W + 3
) (
   input logic             bus_clk,
   input logic             bus_rst_n,
   input logic             cnt_clk,
   input logic             cnt_rst_n,
   input logic [2:0]       stat,
   input logic [2:0]       stat_clr,
   input logic [2:0]       irq_en,
   input logic             irq,
   input logic             pwm_out,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CFG_W-1:0] act_cfg,
   input logic             wrap,
   input logic             cfg_busy,
   input logic [CFG_W-1:0] xfer_cfg
);
   // R8
   sticky_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (($past(stat) & ~$past(stat_clr) & ~stat) == 3'b000));

   // R9
   irq_gate_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (irq_en == 3'b000) |-> !irq);

   // R2
   cnt_bound_chk: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      cnt_val <= act_cfg[CNT_W-1:0]);

   // R6
   cfg_hold_chk: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      !wrap |=> $stable(act_cfg));

   // R3
   duty_zero_chk: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      (act_cfg[2*CNT_W-1:CNT_W] == '0 && !act_cfg[2*CNT_W+2]) |=> !pwm_out);

   // R7
   shadow_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      cfg_busy |=> $stable(xfer_cfg));
endmodule

bind pwm_timer_channel pwm_timer_channel_chk #(.CNT_W(CNT_W)) i_chk (
   .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
   .stat(stat), .stat_clr(stat_clr), .irq_en(irq_en), .irq(irq), .pwm_out(pwm_out),
   .cnt_val(cnt_val), .act_cfg(act_cfg), .wrap(wrap), .cfg_busy(cfg_busy),
   .xfer_cfg(xfer_cfg));

// File: tb/test_pwm_timer_channel.sv
`timescale 1ns/1ps
module test_pwm_timer_channel;
   localparam int CNT_W = 24;

   logic             bus_clk = 1'b0, cnt_clk = 1'b0;
   logic             bus_rst_n = 1'b0, cnt_rst_n = 1'b0;
   logic             cfg_load = 1'b0, cfg_invert = 1'b0;
   logic [CNT_W-1:0] cfg_period = '0, cfg_duty = '0;
   logic [1:0]       cfg_psel = 2'd0;
   logic [2:0]       irq_en = 3'b000, stat_clr = 3'b000, stat;
   logic             irq, pwm_out;

   int checks = 0, errors = 0, cur_len = 1;

   always #2 bus_clk = ~bus_clk;   // 250 MHz
   always #3 cnt_clk = ~cnt_clk;

   pwm_timer_channel #(.CNT_W(CNT_W)) i_pwm_timer_channel (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .cfg_load(cfg_load),
      .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_psel(cfg_psel),
      .cfg_invert(cfg_invert), .irq_en(irq_en), .stat_clr(stat_clr), .stat(stat),
      .irq(irq), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n), .pwm_out(pwm_out));

   function automatic int div_of(input int sel);
      return (sel == 0) ? 1 : (sel == 1) ? 16 : (sel == 2) ? 256 : 2048;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cnt(input int n);
      for (int i = 0; i < n; i++) @(negedge cnt_clk);
   endtask

   task automatic wait_bus(input int n);
      for (int i = 0; i < n; i++) @(negedge bus_clk);
   endtask

   task automatic load(input int per, input int dty, input int sel, input bit inv);
      @(negedge bus_clk);
      cfg_period = CNT_W'(per); cfg_duty = CNT_W'(dty);
      cfg_psel = 2'(sel); cfg_invert = inv; cfg_load = 1'b1;
      @(negedge bus_clk);
      cfg_load = 1'b0;
   endtask

   task automatic apply(input int per, input int dty, input int sel, input bit inv);
      load(per, dty, sel, inv);
      wait_cnt(2*cur_len + 40);
      cur_len = (per + 1) * div_of(sel);
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge cnt_clk);
         if (pwm_out) h++;
      end
   endtask

   task automatic clear_stat(input logic [2:0] m);
      @(negedge bus_clk); stat_clr = m;
      @(negedge bus_clk); stat_clr = 3'b000;
   endtask

   initial begin
      for (int i = 0; i < 190000; i++) @(posedge bus_clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int h, exp;
      wait_bus(8);
      // R1: state during reset and just after release
      chk("R1 pwm_out in reset", int'(pwm_out), 0);
      chk("R1 stat in reset", int'(stat), 0);
      bus_rst_n = 1'b1; cnt_rst_n = 1'b1;
      @(negedge bus_clk);
      chk("R1 pwm_out after reset", int'(pwm_out), 0);
      chk("R1 irq after reset", int'(irq), 0);

      // R2 / R3: duty sweep, period 5 (6 ticks per cycle), two cycles counted
      for (int d = 0; d <= 6; d++) begin
         apply(5, d, 0, 1'b0);
         count_high(12, h);
         exp = (d == 0) ? 0 : (d >= 5) ? 12 : 2*d;
         chk((d == 0 || d >= 5) ? "R3 duty bound" : "R2 duty ticks", h, exp);
      end

      // R4: inversion
      apply(5, 2, 0, 1'b1);
      count_high(12, h);
      chk("R4 inverted duty 2", h, 8);
      apply(5, 0, 0, 1'b1);
      count_high(12, h);
      chk("R4 inverted duty 0", h, 12);

      // R7: two loads back to back, the second must win
      load(5, 1, 0, 1'b0);
      load(5, 3, 0, 1'b0);
      wait_cnt(2*cur_len + 60);
      count_high(12, h);
      chk("R7 latest load wins", h, 6);

      // R8 / R9: flags and interrupt gating
      apply(3, 1, 0, 1'b0);
      clear_stat(3'b111);
      wait_bus(30);
      chk("R8 all events flagged", int'(stat), 7);
      irq_en = 3'b000; @(negedge bus_clk);
      chk("R9 irq with no enables", int'(irq), 0);
      irq_en = 3'b010; @(negedge bus_clk);
      chk("R9 irq from fall flag", int'(irq), 1);
      irq_en = 3'b000;
      apply(3, 0, 0, 1'b0);
      clear_stat(3'b011);
      wait_bus(40);
      chk("R8 edge flags cleared, wrap kept", int'(stat), 4);
      irq_en = 3'b011; @(negedge bus_clk);
      chk("R9 irq with cleared flags", int'(irq), 0);
      irq_en = 3'b100; @(negedge bus_clk);
      chk("R9 irq from wrap flag", int'(irq), 1);
      irq_en = 3'b000;

      // R5: tick rate, period 3 duty 1 -> active one tick of four
      for (int s = 0; s < 4; s++) begin
         apply(3, 1, s, 1'b0);
         count_high(4*div_of(s), h);
         chk("R5 prescaler ratio", h, div_of(s));
      end

      // R6: a load just after a wrap must not alter the running cycle
      apply(200, 100, 0, 1'b0);
      clear_stat(3'b100);
      while (!stat[2]) @(negedge bus_clk);
      load(200, 200, 0, 1'b0);
      wait_cnt(125);
      count_high(40, h);
      chk("R6 old duty kept until wrap", h, 0);
      wait_cnt(402);
      count_high(201, h);
      chk("R6 new duty after wrap", h, 201);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule